// File: doc/BRIEF.md
# Copy Command Packet Builder

This block turns one memory copy request into a command packet of ten 32-bit words for a copy engine. A request carries a 64-bit source offset, a 64-bit destination offset, a byte count, a row pitch and a 4-bit cache-policy index. The builder chooses one of three transfer modes from the alignment of the request. It encodes every count field as its value minus one and streams the words out over a valid/ready handshake.

The first mode moves whole 256-byte pages. The second is a byte-granular two-dimensional transfer in which each row is one pitch wide. The third is a byte-granular linear run. A request that would overflow a packet field, or that is malformed, is not emitted. The builder instead raises a one-cycle error pulse and is ready again at once. A done pulse marks the end of each packet that is sent.

Top module: `copy_pkt_builder`

## Requirements
- R1: Word 0 carries the fixed opcode 0x56800008. It is ORed with a page flag at bit 19 and a two-dimensional flag at bit 17, and no other header bits are ever set.
- R2: When the byte count and bits 31:0 of both offsets are all multiples of 256, page mode is used. In page mode, bit 19 is set, bit 17 is clear, and word 1 holds count/256 − 1.
- R3: When page mode does not apply and the pitch is above 1, the two-dimensional mode is used. In this mode, bit 17 is set, bit 19 is clear, word 1 holds pitch − 1 and word 2 holds count/pitch − 1.
- R4: When page mode does not apply and the pitch equals 1, the linear mode is used. In linear mode, both flags are clear and word 1 holds count − 1.
- R5: Words 1 to 9 come in this fixed order:
  - word 1: the width field;
  - word 2: count/pitch − 1;
  - word 3: pitch − 1;
  - word 4: pitch − 1 again;
  - word 5: source bits 31:0;
  - word 6: source bits 63:32;
  - word 7: destination bits 31:0;
  - word 8: destination bits 63:32;
  - word 9: the cache-policy word.
- R6: In word 9, the cache-policy index sits in bits 31:28 and again in bits 6:3. All other bits of word 9 are zero.
- R7: A request is rejected if any of the following holds: the pitch is zero; the pitch is above 65535; the count is zero; the count is not a multiple of the pitch; the width is above 65535; or, in the two-dimensional mode, the row count is above 65535. A rejected request gives exactly one cycle of error pulse in the cycle after it is accepted, sends no word, and leaves the request side ready.
- R8: A word that is offered while the consumer is not ready stays unchanged until it is taken. The ten words leave in order, one per handshake.
- R9: Requests are taken only while no packet is in flight, and request inputs seen during a transfer are ignored. A done pulse lasting one cycle follows the cycle in which word 9 is taken.
- R10: In page mode, word 2 still carries count/pitch − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Builder idle; a request is taken this cycle |
| req_src | input | 64 | Source byte offset |
| req_dst | input | 64 | Destination byte offset |
| req_size | input | 32 | Byte count |
| req_pitch | input | 32 | Row pitch in bytes |
| req_cpi | input | 4 | Cache-policy index |
| pkt_valid | output | 1 | Packet word on pkt_data |
| pkt_ready | input | 1 | Consumer takes the word |
| pkt_data | output | 32 | Packet word |
| err_pulse | output | 1 | Request rejected |
| done_pulse | output | 1 | Packet completed |

## Verification
The builder takes a request on the clock edge where req_valid and req_ready are both high. The error pulse, or word 0, is visible one cycle after that edge. Each later word appears one cycle after the edge where the previous word was taken, and the done pulse appears one cycle after the edge that takes word 9. The bench changes inputs on the falling edge and samples at the next falling edge, which counts exactly one register stage for each of these results. During stalls it re-checks the held word on every cycle.

// File: rtl/cpb_pkg.sv
// Shared constants and types for the copy command packet builder.
// Assumes a fixed ten-word packet with 16-bit count fields.
package cpb_pkg;
    localparam logic [31:0] CPB_OPCODE      = 32'h5680_0008;
    localparam int          PAGE_FLAG_BIT   = 19;
    localparam int          MATRIX_FLAG_BIT = 17;
    localparam int          SRC_CPI_LSB     = 28;
    localparam int          DST_CPI_LSB     = 3;
    localparam int          PKT_WORDS       = 10;
    localparam int          CNT_W           = 16;
    localparam int          CPI_W           = 4;

    typedef enum logic [1:0] {
        MODE_PAGE   = 2'd0,
        MODE_MATRIX = 2'd1,
        MODE_LINEAR = 2'd2
    } copy_mode_e;

    typedef struct packed {
        copy_mode_e         mode;
        logic [CNT_W-1:0]   width_m1;
        logic [31:0]        rows_m1;
        logic [CNT_W-1:0]   pitch_m1;
        logic [63:0]        src;
        logic [63:0]        dst;
        logic [CPI_W-1:0]   cpi;
    } copy_cmd_t;
endpackage

// File: rtl/cpb_classify.sv
// Chooses the transfer mode for a raw request, derives the field values
// and flags any request that breaks a field limit.
// Purely combinational; assumes PAGE_BYTES is a power of two above 1.
module cpb_classify
    import cpb_pkg::*;
#(
    parameter int PAGE_BYTES = 256
) (
    input  logic [63:0]      src,
    input  logic [63:0]      dst,
    input  logic [31:0]      size,
    input  logic [31:0]      pitch,
    input  logic [CPI_W-1:0] cpi,
    output copy_cmd_t        cmd,
    output logic             bad
);
    localparam int          PAGE_LG = $clog2(PAGE_BYTES);
    localparam logic [31:0] CNT_MAX = (32'd1 << CNT_W) - 32'd1;

    logic             pitch_ok;
    logic [CNT_W-1:0] divisor;
    logic [31:0]      rows;
    logic [31:0]      rem;
    logic             page_ok;
    logic [31:0]      width;
    copy_mode_e       mode;

    // Guard the divider, then split the count into rows and a remainder.
    always_comb begin
        pitch_ok = (pitch != 32'd0) && (pitch <= CNT_MAX);
        divisor  = pitch_ok ? pitch[CNT_W-1:0] : {{(CNT_W-1){1'b0}}, 1'b1};
        rows     = size / {{(32-CNT_W){1'b0}}, divisor};
        rem      = size % {{(32-CNT_W){1'b0}}, divisor};
    end

    // Pick the mode from alignment first, then from the pitch.
    always_comb begin
        page_ok = (size[PAGE_LG-1:0] == '0) && (src[PAGE_LG-1:0] == '0) &&
                  (dst[PAGE_LG-1:0] == '0);
        if (page_ok) begin
            mode  = MODE_PAGE;
            width = size >> PAGE_LG;
        end else if (pitch > 32'd1) begin
            mode  = MODE_MATRIX;
            width = pitch;
        end else begin
            mode  = MODE_LINEAR;
            width = size;
        end
    end

    // Collect every limit violation into one reject flag.
    always_comb begin
        bad = !pitch_ok || (size == 32'd0) || (rem != 32'd0) ||
              (width > CNT_MAX) || ((mode == MODE_MATRIX) && (rows > CNT_MAX));
    end

    // Encode the stored fields as value minus one.
    always_comb begin
        cmd.mode     = mode;
        cmd.width_m1 = width[CNT_W-1:0] - 1'b1;
        cmd.rows_m1  = rows - 32'd1;
        cmd.pitch_m1 = pitch[CNT_W-1:0] - 1'b1;
        cmd.src      = src;
        cmd.dst      = dst;
        cmd.cpi      = cpi;
    end
endmodule

// File: rtl/cpb_encoder.sv
// Maps a stored command and a word index onto one packet word.
// Combinational; assumes the index stays below PKT_WORDS.
module cpb_encoder
    import cpb_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  copy_cmd_t        cmd,
    input  logic [IDX_W-1:0] idx,
    output logic [31:0]      word
);
    logic [31:0] header;
    logic [31:0] policy;

    // Build the header and the cache-policy word.
    always_comb begin
        header                  = CPB_OPCODE;
        header[PAGE_FLAG_BIT]   = (cmd.mode == MODE_PAGE);
        header[MATRIX_FLAG_BIT] = (cmd.mode == MODE_MATRIX);
        policy                  = '0;
        policy[SRC_CPI_LSB +: CPI_W] = cmd.cpi;
        policy[DST_CPI_LSB +: CPI_W] = cmd.cpi;
    end

    // Select the word for the current position in the packet.
    always_comb begin
        case (idx)
            IDX_W'(0): word = header;
            IDX_W'(1): word = {{(32-CNT_W){1'b0}}, cmd.width_m1};
            IDX_W'(2): word = cmd.rows_m1;
            IDX_W'(3): word = {{(32-CNT_W){1'b0}}, cmd.pitch_m1};
            IDX_W'(4): word = {{(32-CNT_W){1'b0}}, cmd.pitch_m1};
            IDX_W'(5): word = cmd.src[31:0];
            IDX_W'(6): word = cmd.src[63:32];
            IDX_W'(7): word = cmd.dst[31:0];
            IDX_W'(8): word = cmd.dst[63:32];
            IDX_W'(9): word = policy;
            default:   word = '0;
        endcase
    end
endmodule

// File: rtl/cpb_sequencer.sv
// Control for the builder: takes requests in idle, rejects bad ones with a
// pulse, and steps the word index on each output handshake.
// Assumes `bad` is valid in the same cycle as req_valid.
module cpb_sequencer #(
    parameter int WORDS = 10,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             bad,
    input  logic             out_ready,
    output logic             req_ready,
    output logic             load,
    output logic             out_valid,
    output logic [IDX_W-1:0] idx,
    output logic             err_pulse,
    output logic             done_pulse
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    typedef enum logic {ST_IDLE, ST_SEND} seq_state_e;
    seq_state_e state;

    // Decode handshake-side outputs from the state.
    always_comb begin
        req_ready = (state == ST_IDLE);
        out_valid = (state == ST_SEND);
        load      = req_ready && req_valid && !bad;
    end

    // Advance the state, the index and the one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            idx        <= '0;
            err_pulse  <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            err_pulse  <= 1'b0;
            done_pulse <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (bad) begin
                            err_pulse <= 1'b1;
                        end else begin
                            state <= ST_SEND;
                            idx   <= '0;
                        end
                    end
                end
                ST_SEND: begin
                    if (out_ready) begin
                        if (idx == LAST_IDX) begin
                            state      <= ST_IDLE;
                            done_pulse <= 1'b1;
                            idx        <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/copy_pkt_builder.sv
// Top of the copy command packet builder: classifies a request, latches the
// encoded command and streams ten words under valid/ready.
// Assumes the consumer follows valid/ready; one packet in flight at a time.
module copy_pkt_builder
    import cpb_pkg::*;
#(
    parameter int PAGE_BYTES = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [63:0]      req_src,
    input  logic [63:0]      req_dst,
    input  logic [31:0]      req_size,
    input  logic [31:0]      req_pitch,
    input  logic [CPI_W-1:0] req_cpi,
    output logic             pkt_valid,
    input  logic             pkt_ready,
    output logic [31:0]      pkt_data,
    output logic             err_pulse,
    output logic             done_pulse
);
    localparam int IDX_W = $clog2(PKT_WORDS);

    copy_cmd_t        cmd_c;
    copy_cmd_t        cmd_q;
    logic             bad_c;
    logic             load;
    logic [IDX_W-1:0] seq_idx;

    cpb_classify #(.PAGE_BYTES(PAGE_BYTES)) u_classify (
        .src   (req_src),
        .dst   (req_dst),
        .size  (req_size),
        .pitch (req_pitch),
        .cpi   (req_cpi),
        .cmd   (cmd_c),
        .bad   (bad_c)
    );

    // Hold the encoded command for the whole packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (load) begin
            cmd_q <= cmd_c;
        end
    end

    cpb_sequencer #(.WORDS(PKT_WORDS), .IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .bad        (bad_c),
        .out_ready  (pkt_ready),
        .req_ready  (req_ready),
        .load       (load),
        .out_valid  (pkt_valid),
        .idx        (seq_idx),
        .err_pulse  (err_pulse),
        .done_pulse (done_pulse)
    );

    cpb_encoder #(.IDX_W(IDX_W)) u_enc (
        .cmd  (cmd_q),
        .idx  (seq_idx),
        .word (pkt_data)
    );
endmodule

// File: rtl/cpb_checker.sv
// Protocol and format properties for the packet builder, bound to its top.
// Assumes the internal word index is four bits wide.
module cpb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        pkt_valid,
    input logic        pkt_ready,
    input logic [31:0] pkt_data,
    input logic        err_pulse,
    input logic        done_pulse,
    input logic [3:0]  word_idx
);
    p_hdr_opcode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && word_idx == 4'd0) |->
            ((pkt_data & ~32'h000A_0000) == 32'h5680_0008));

    p_mode_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && word_idx == 4'd0) |-> !(pkt_data[19] && pkt_data[17]));

    p_first_is_hdr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_valid) |-> (word_idx == 4'd0));

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready && word_idx != 4'd9) |=>
            (pkt_valid && word_idx == $past(word_idx) + 4'd1));

    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (!pkt_valid && req_ready));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data)));

    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> !req_ready);

    p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready && word_idx == 4'd9) |=> (done_pulse && !pkt_valid));
endmodule

bind copy_pkt_builder cpb_checker u_cpb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .pkt_valid  (pkt_valid),
    .pkt_ready  (pkt_ready),
    .pkt_data   (pkt_data),
    .err_pulse  (err_pulse),
    .done_pulse (done_pulse),
    .word_idx   (seq_idx)
);

// File: tb/tb_copy_pkt_builder.sv
// Directed bench for the copy command packet builder.
module tb_copy_pkt_builder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_src = '0;
    logic [63:0] req_dst = '0;
    logic [31:0] req_size = '0;
    logic [31:0] req_pitch = '0;
    logic [3:0]  req_cpi = '0;
    logic        pkt_valid;
    logic        pkt_ready = 1'b0;
    logic [31:0] pkt_data;
    logic        err_pulse;
    logic        done_pulse;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    copy_pkt_builder dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_src(req_src), .req_dst(req_dst), .req_size(req_size),
        .req_pitch(req_pitch), .req_cpi(req_cpi), .pkt_valid(pkt_valid),
        .pkt_ready(pkt_ready), .pkt_data(pkt_data), .err_pulse(err_pulse),
        .done_pulse(done_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Expected word k of a packet, derived from the requirements.
    function automatic logic [31:0] exp_word(input logic [63:0] s, input logic [63:0] d,
                                             input logic [31:0] sz, input logic [31:0] p,
                                             input logic [3:0] c, input int k);
        logic        pg, mx;
        logic [31:0] w;
        pg = (sz[7:0] == 8'h00) && (s[7:0] == 8'h00) && (d[7:0] == 8'h00);
        mx = !pg && (p > 32'd1);
        w  = pg ? (sz >> 8) : (mx ? p : sz);
        case (k)
            0: return 32'h5680_0008 | (pg ? 32'h0008_0000 : 32'h0) | (mx ? 32'h0002_0000 : 32'h0);
            1: return w - 32'd1;
            2: return sz / p - 32'd1;
            3, 4: return p - 32'd1;
            5: return s[31:0];
            6: return s[63:32];
            7: return d[31:0];
            8: return d[63:32];
            default: return {c, 21'b0, c, 3'b0};
        endcase
    endfunction

    // Send one good request and check all ten words plus the done pulse.
    task automatic run_copy(input string mode_req, input logic [63:0] s, input logic [63:0] d,
                            input logic [31:0] sz, input logic [31:0] p, input logic [3:0] c,
                            input bit stall);
        int n;
        string tag;
        @(negedge clk);
        req_src = s; req_dst = d; req_size = sz; req_pitch = p; req_cpi = c;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 busy blocks requests", {31'b0, req_ready}, 32'd0);
        if (stall) begin
            // R9: junk request inputs while busy must have no effect
            req_src = 64'hFFFF_FFFF_FFFF_FFFF; req_dst = '0; req_size = 32'd3; req_pitch = 32'd0;
            req_cpi = 4'h0;
        end
        n = 0;
        for (int cyc = 0; cyc < 100 && n < 10; cyc++) begin
            pkt_ready = stall ? ((cyc % 3) != 1) : 1'b1;
            req_valid = stall && (n < 5);
            if (pkt_valid) begin
                if (n == 0) tag = mode_req;
                else if (n == 2 && mode_req == "R2") tag = "R10";
                else if (n == 9) tag = "R6";
                else if (!pkt_ready) tag = "R8";
                else tag = "R5";
                check(tag, pkt_data, exp_word(s, d, sz, p, c, n));
                if (n == 1) check(mode_req, pkt_data, exp_word(s, d, sz, p, c, 1));
                if (pkt_ready) n++;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        pkt_ready = 1'b0;
        check("R8 ten words delivered", n, 32'd10);
        check("R9 done pulse", {31'b0, done_pulse}, 32'd1);
        check("R9 idle after packet", {30'b0, req_ready, pkt_valid}, 32'd2);
        @(negedge clk);
        check("R9 done lasts one cycle", {31'b0, done_pulse}, 32'd0);
    endtask

    // Send one bad request and check the reject behaviour.
    task automatic run_bad(input string why, input logic [63:0] s, input logic [31:0] sz,
                           input logic [31:0] p);
        @(negedge clk);
        req_src = s; req_dst = 64'h0; req_size = sz; req_pitch = p; req_cpi = 4'h5;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({"R7 error pulse ", why}, {31'b0, err_pulse}, 32'd1);
        check({"R7 no word, still ready ", why}, {30'b0, pkt_valid, req_ready}, 32'd1);
        @(negedge clk);
        check({"R7 one-cycle pulse ", why}, {30'b0, err_pulse, pkt_valid}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset state", {28'b0, req_ready, pkt_valid, err_pulse, done_pulse}, 32'h8);
        // R2 / R10 page mode with nonzero high offset words
        run_copy("R2", 64'h0000_0012_0000_1000, 64'h0000_0034_0000_2200, 32'd4096, 32'd64, 4'hA, 1'b0);
        // R3 two-dimensional mode: unaligned source
        run_copy("R3", 64'h0000_0000_0000_0010, 64'h0000_0001_0000_0100, 32'd300, 32'd100, 4'h3, 1'b0);
        // R4 linear mode at the width limit
        run_copy("R4", 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002, 32'd65535, 32'd1, 4'hF, 1'b0);
        // R1 / R8 / R9 with back-pressure and junk requests while busy
        run_copy("R1", 64'h8000_0000_1234_5601, 64'h0000_0000_0000_0300, 32'd512, 32'd256, 4'h6, 1'b1);
        // R7 limit violations
        run_bad("pitch zero", 64'h1, 32'd16, 32'd0);
        run_bad("size zero", 64'h1, 32'd0, 32'd4);
        run_bad("not multiple", 64'h1, 32'd10, 32'd3);
        run_bad("pitch too big", 64'h1, 32'd65536, 32'd65536);
        run_bad("linear width", 64'h1, 32'd65536, 32'd1);
        run_bad("page width", 64'h0, 32'h0100_0000, 32'd1);
        run_bad("matrix rows", 64'h1, 32'd131072, 32'd2);
        // R7 recovery: a good request right after rejects still works
        run_copy("R3", 64'h0000_0000_0000_0003, 64'h0, 32'd12, 32'd4, 4'h1, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule